// File: doc/BRIEF.md
# ULPI Link Power-Up Sequencer

This block sits on the link side of a ULPI transceiver interface and takes the PHY from power-on to a quiet, usable bus. It runs on the 60 MHz clock that the PHY supplies, observes the direction and next-data strobes, and drives the eight data lines and the stop strobe. It first waits out a window in which the PHY's pins are undefined. It then waits for the PHY to hand the bus over by lowering its direction line. Once it holds the bus, it drives the idle pattern and sends a single register write that resets the PHY. Finally it waits for the PHY to report status through a receive command before it declares the bus ready.

When the PHY takes the bus back in the middle of the reset write, the write is dropped and started again from the command byte once the bus is free. If no status update follows the write within a limit set at a port, the block raises a sticky error instead of a ready flag. The idle pattern is all-zero data with the stop strobe low. Whenever the direction input is high, the data output enable and the stop strobe are both held low.

Top module: `ulpi_bringup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ulpi_data_oe`, `ulpi_stp`, `bus_ready` and `tmo_err` are all 0.
- R2: For IGNORE_CYCLES clock edges after reset (at least one), the levels on `ulpi_dir` and `ulpi_nxt` have no effect. A high-to-low move of `ulpi_dir` inside that window does not count as a bus release, and the bus is not driven while the window lasts.
- R3: In any cycle where `ulpi_dir` is 1, `ulpi_data_oe` is 0 and `ulpi_stp` is 0.
- R4: A bus release is `ulpi_dir` sampled 1 at one edge and 0 at the next. It is followed by exactly one turnaround cycle in which `ulpi_data_oe` stays 0.
- R5: After the turnaround cycle comes one idle cycle with `ulpi_data_oe`=1, `ulpi_data_o`=0x00 and `ulpi_stp`=0. The write then begins.
- R6: The write drives the register-write command byte, 0x80 OR the 6-bit address (default address 0x05, giving 0x85), until `ulpi_nxt` is sampled 1. It then drives the data byte (default 0x20) until `ulpi_nxt` is sampled 1 again.
- R7: In the cycle after the data byte is accepted, `ulpi_stp`=1 and `ulpi_data_o`=0x00 for exactly one cycle. The bus then returns to idle driving.
- R8: If `ulpi_dir` is sampled 1 while the command or data byte is being offered, the write is aborted. After the next release, the turnaround and idle cycles repeat and the write restarts with the command byte.
- R9: After the write, `ulpi_dir` sampled 1 and then sampled 0 gives one turnaround cycle. After that, `bus_ready` becomes 1 with idle driving, and it stays 1 until reset.
- R10: If `ulpi_dir` has not been sampled 1 by the L-th edge after the first post-write idle cycle (L = `tmo_limit`, where 0 acts as 1), `tmo_err` becomes 1 at that edge and stays 1. `bus_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock from the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| ulpi_dir | input | 1 | Bus direction from the PHY, 1 = PHY drives |
| ulpi_nxt | input | 1 | PHY throttle strobe, 1 = byte accepted |
| ulpi_data_o | output | 8 | Data byte driven by the link |
| ulpi_data_oe | output | 1 | Output enable for the data lines |
| ulpi_stp | output | 1 | Stop strobe to the PHY |
| tmo_limit | input | TMO_W | Cycles allowed for the status update after the write |
| bus_ready | output | 1 | Bus is up and idle |
| tmo_err | output | 1 | Status update did not arrive in time |

## Verification
Each bring-up starts with random noise on the direction and throttle lines inside the ignore window, followed by a release edge that falls inside that window. A design that reacts to early levels leaves the bus undriven too late or drives it too early. The throttle strobe is held off for random numbers of cycles on both bytes, which separates a write that waits for acceptance from one that runs on a fixed cadence. Aborts are injected during the command phase and during the data phase, so a restart from the command byte can be told apart from a resume at the data byte. The status update is placed at random offsets up to the last permitted edge, or left out, including a limit of zero. This pins down the boundary between ready and timeout.

// File: rtl/ulpi_seq_pkg.sv
package ulpi_seq_pkg;

   typedef enum logic [3:0] {
      ST_IGNORE,
      ST_WAIT_REL,
      ST_TURN,
      ST_IDLE,
      ST_CMD,
      ST_DAT,
      ST_STP,
      ST_WAIT_RX,
      ST_RX,
      ST_TURN_RX,
      ST_READY,
      ST_FAIL
   } seq_state_t;

   localparam logic [7:0] TXCMD_REGWR_BASE = 8'h80;

   function automatic logic [7:0] regwr_cmd(input logic [5:0] addr);
      return TXCMD_REGWR_BASE | {2'b00, addr};
   endfunction

endpackage

// File: rtl/ulpi_dir_edge.sv
module ulpi_dir_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   output logic dir_fall
);
   logic dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir;
   end

   assign dir_fall = dir_q & ~dir;
endmodule

// File: rtl/ulpi_cycle_ctr.sv
module ulpi_cycle_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;
   logic [W:0]   cnt_next;

   initial begin : p_chk_w
      assert (W >= 1) else $error("ulpi_cycle_ctr: W must be at least 1");
   end

   assign cnt_next = {1'b0, cnt} + (W+1)'(1);
   assign hit      = cnt_next >= {1'b0, limit};

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (en && !hit) cnt <= cnt_next[W-1:0];
   end

   a_r10_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/ulpi_tx_drive.sv
module ulpi_tx_drive
   import ulpi_seq_pkg::*;
#(
   parameter logic [7:0] CMD_BYTE = 8'h85,
   parameter logic [7:0] DAT_BYTE = 8'h20
) (
   input  seq_state_t state,
   input  logic       dir,
   output logic [7:0] data_o,
   output logic       data_oe,
   output logic       stp
);
   logic drive_req;
   logic stp_req;

   always_comb begin
      data_o    = 8'h00;
      drive_req = 1'b0;
      stp_req   = 1'b0;
      unique case (state)
         ST_IDLE, ST_WAIT_RX, ST_READY, ST_FAIL: drive_req = 1'b1;
         ST_CMD: begin drive_req = 1'b1; data_o = CMD_BYTE; end
         ST_DAT: begin drive_req = 1'b1; data_o = DAT_BYTE; end
         ST_STP: begin drive_req = 1'b1; stp_req = 1'b1; end
         default: ;
      endcase
   end

   assign data_oe = drive_req & ~dir;
   assign stp     = stp_req & ~dir;
endmodule

// File: rtl/ulpi_bringup_seq.sv
module ulpi_bringup_seq
   import ulpi_seq_pkg::*;
#(
   parameter int         IGNORE_CYCLES = 16,
   parameter int         TMO_W         = 16,
   parameter int         DATA_W        = 8,
   parameter int         PHY_RST_ADDR  = 5,
   parameter logic [7:0] PHY_RST_DATA  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ulpi_dir,
   input  logic              ulpi_nxt,
   output logic [DATA_W-1:0] ulpi_data_o,
   output logic              ulpi_data_oe,
   output logic              ulpi_stp,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              bus_ready,
   output logic              tmo_err
);
   localparam int         IGN_W    = (IGNORE_CYCLES < 2) ? 1 : $clog2(IGNORE_CYCLES + 1);
   localparam logic [5:0] RST_ADDR = PHY_RST_ADDR[5:0];
   localparam logic [7:0] CMD_BYTE = regwr_cmd(RST_ADDR);

   initial begin : p_param_chk
      assert (DATA_W == 8)        else $error("ulpi_bringup_seq: DATA_W must be 8");
      assert (PHY_RST_ADDR >= 0 && PHY_RST_ADDR < 64)
                                  else $error("ulpi_bringup_seq: address must fit in 6 bits");
      assert (IGNORE_CYCLES >= 0) else $error("ulpi_bringup_seq: IGNORE_CYCLES negative");
      assert (TMO_W >= 1)         else $error("ulpi_bringup_seq: TMO_W must be at least 1");
   end

   seq_state_t state, state_nx;
   logic       dir_fall;
   logic       ign_hit;
   logic       tmo_hit;
   logic [7:0] data_byte;

   ulpi_dir_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir      (ulpi_dir),
      .dir_fall (dir_fall)
   );

   generate
      if (IGNORE_CYCLES <= 1) begin : g_ign_short
         assign ign_hit = 1'b1;
      end else begin : g_ign_ctr
         ulpi_cycle_ctr #(.W(IGN_W)) u_ign (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (1'b0),
            .en    (state == ST_IGNORE),
            .limit (IGNORE_CYCLES[IGN_W-1:0]),
            .hit   (ign_hit)
         );
      end
   endgenerate

   ulpi_cycle_ctr #(.W(TMO_W)) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != ST_WAIT_RX),
      .en    (state == ST_WAIT_RX),
      .limit (tmo_limit),
      .hit   (tmo_hit)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IGNORE:   if (ign_hit) state_nx = ST_WAIT_REL;
         ST_WAIT_REL: if (dir_fall) state_nx = ST_TURN;
         ST_TURN:     state_nx = ulpi_dir ? ST_WAIT_REL : ST_IDLE;
         ST_IDLE:     state_nx = ulpi_dir ? ST_WAIT_REL : ST_CMD;
         ST_CMD: begin
            if (ulpi_dir)      state_nx = ST_WAIT_REL;
            else if (ulpi_nxt) state_nx = ST_DAT;
         end
         ST_DAT: begin
            if (ulpi_dir)      state_nx = ST_WAIT_REL;
            else if (ulpi_nxt) state_nx = ST_STP;
         end
         ST_STP:      state_nx = ST_WAIT_RX;
         ST_WAIT_RX: begin
            if (ulpi_dir)     state_nx = ST_RX;
            else if (tmo_hit) state_nx = ST_FAIL;
         end
         ST_RX:       if (!ulpi_dir) state_nx = ST_TURN_RX;
         ST_TURN_RX:  state_nx = ulpi_dir ? ST_RX : ST_READY;
         ST_READY:    state_nx = ST_READY;
         ST_FAIL:     state_nx = ST_FAIL;
         default:     state_nx = ST_IGNORE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IGNORE;
      else        state <= state_nx;
   end

   ulpi_tx_drive #(.CMD_BYTE(CMD_BYTE), .DAT_BYTE(PHY_RST_DATA)) u_drv (
      .state   (state),
      .dir     (ulpi_dir),
      .data_o  (data_byte),
      .data_oe (ulpi_data_oe),
      .stp     (ulpi_stp)
   );

   assign ulpi_data_o = data_byte;
   assign bus_ready   = (state == ST_READY);
   assign tmo_err     = (state == ST_FAIL);

   a_r7_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_stp |=> !ulpi_stp);

   a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> bus_ready);

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |=> (tmo_err && !bus_ready));

   a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD && !ulpi_dir && !ulpi_nxt) |=> (ulpi_data_o == CMD_BYTE));

   a_r5_idle_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> ($past(state) == ST_TURN));

   a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_CMD || state == ST_DAT) && ulpi_dir) |=> (state == ST_WAIT_REL));
endmodule

// File: tb/ulpi_bringup_seq_test.sv
`timescale 1ns/1ps
module ulpi_bringup_seq_test;
   localparam int IGN = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dir;
   logic        nxt;
   logic [7:0]  dout;
   logic        oe;
   logic        stp;
   logic [15:0] lim;
   logic        rdy;
   logic        err;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ulpi_bringup_seq #(.IGNORE_CYCLES(IGN)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ulpi_dir     (dir),
      .ulpi_nxt     (nxt),
      .ulpi_data_o  (dout),
      .ulpi_data_oe (oe),
      .ulpi_stp     (stp),
      .tmo_limit    (lim),
      .bus_ready    (rdy),
      .tmo_err      (err)
   );

   function automatic int regwr_byte(input int addr);
      return 'h80 | (addr & 'h3f);
   endfunction

   function automatic int eff_limit(input int l);
      return (l == 0) ? 1 : l;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bring_up(input int nxt_c, input int nxt_d, input int abort_at,
                           input int l, input int arrive);
      bit aborted = 0;
      bit done = 0;
      rst_n = 0; dir = 1; nxt = 0; lim = 16'(l);
      tick(); tick(); tick();
      chk("R1 oe", int'(oe), 0);
      chk("R1 stp", int'(stp), 0);
      chk("R1 ready", int'(rdy), 0);
      chk("R1 err", int'(err), 0);
      rst_n = 1;
      dir = 0;
      #0;
      chk("R1 oe after release", int'(oe), 0);
      for (int i = 1; i <= IGN + 4; i++) begin
         if (i < IGN - 2)       dir = 1'($urandom);
         else if (i == IGN - 2) dir = 1'b1;
         else                   dir = 1'b0;
         nxt = 1'($urandom);
         tick();
         chk("R2 quiet window", int'(oe), 0);
      end
      nxt = 0;
      dir = 1;
      tick(); tick();
      chk("R3 oe with dir high", int'(oe), 0);
      chk("R3 stp with dir high", int'(stp), 0);
      while (!done) begin
         dir = 0;
         tick();
         chk("R4 turnaround", int'(oe), 0);
         tick();
         chk("R5 idle oe", int'(oe), 1);
         chk("R5 idle data", int'(dout), 0);
         chk("R5 idle stp", int'(stp), 0);
         tick();
         chk("R6 cmd byte", int'(dout), regwr_byte(5));
         chk("R6 cmd oe", int'(oe), 1);
         for (int k = 0; k < nxt_c; k++) begin
            tick();
            chk("R6 cmd held", int'(dout), regwr_byte(5));
         end
         if (abort_at == 1 && !aborted) begin
            aborted = 1;
            dir = 1; nxt = 1;
            #1 chk("R3 abort no drive", int'(oe), 0);
            tick();
            chk("R8 aborted in cmd", int'(oe), 0);
            nxt = 0;
            tick();
            continue;
         end
         nxt = 1;
         tick();
         chk("R6 data byte", int'(dout), 'h20);
         nxt = 0;
         for (int k = 0; k < nxt_d; k++) begin
            tick();
            chk("R6 data held", int'(dout), 'h20);
         end
         if (abort_at == 2 && !aborted) begin
            aborted = 1;
            dir = 1; nxt = 1;
            tick();
            chk("R8 aborted in data", int'(oe), 0);
            nxt = 0;
            tick();
            continue;
         end
         nxt = 1;
         tick();
         chk("R7 stp high", int'(stp), 1);
         chk("R7 stp data", int'(dout), 0);
         chk("R7 stp oe", int'(oe), 1);
         nxt = 0;
         tick();
         chk("R7 stp single", int'(stp), 0);
         chk("R7 idle after stp", int'(oe), 1);
         done = 1;
      end
      if (arrive >= 0) begin
         for (int t = 0; t < arrive; t++) begin
            tick();
            chk("R10 no early err", int'(err), 0);
         end
         dir = 1;
         #1 chk("R3 rx no drive", int'(oe), 0);
         tick(); tick();
         dir = 0;
         tick();
         chk("R9 turnaround ready", int'(rdy), 0);
         chk("R9 turnaround oe", int'(oe), 0);
         tick();
         chk("R9 ready", int'(rdy), 1);
         chk("R9 idle data", int'(dout), 0);
         chk("R9 idle oe", int'(oe), 1);
         for (int t = 0; t < 3; t++) begin
            tick();
            chk("R9 ready sticky", int'(rdy), 1);
            chk("R10 no err when ready", int'(err), 0);
         end
      end else begin
         for (int t = 1; t < eff_limit(l); t++) begin
            tick();
            chk("R10 err not yet", int'(err), 0);
         end
         tick();
         chk("R10 err raised", int'(err), 1);
         chk("R10 ready low", int'(rdy), 0);
         dir = 1;
         tick();
         dir = 0;
         tick(); tick();
         chk("R10 err sticky", int'(err), 1);
         chk("R10 ready stays low", int'(rdy), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; dir = 1; nxt = 0; lim = 16'd10;
      bring_up(0, 0, 0, 10, 3);
      bring_up(3, 2, 1, 6, -1);
      bring_up(1, 4, 2, 0, -1);
      bring_up(0, 0, 0, 5, 4);
      for (int n = 0; n < 25; n++) begin
         int l  = 1 + int'($urandom % 20);
         int ar = ($urandom % 2 == 0) ? int'($urandom % l) : -1;
         bring_up(int'($urandom % 5), int'($urandom % 5), int'($urandom % 3), l, ar);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule